// File: doc/BRIEF.md
# Counter-Decoder Power-On Sequencer

This block brings an embedded system up one hardware step at a time. A small binary counter advances on qualified clock ticks. Its value is decoded into one-hot step enables in this order: battery test, memory test, disk start, display power-up, boot-block read and CPU start. The two spare decoder codes, zero and seven, enable nothing.

In hold mode, the CPU-start enable is fed back to gate the counter's advance. The sequence therefore stops on its last step instead of wrapping. A restart pulse runs it again from the beginning. In repeat mode the feedback is bypassed, so the counter wraps from seven to zero and the sequence loops forever.

Everything is synchronous. The count enable is gated, never the clock. The step enables come straight from flops, so they show no decode glitches. The block has no data stream, so all of its pins are plain control and status.

Top module: `pwr_seq_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) makes `slot` 0 and every `step_en` bit 0 after that edge.
- R2: When `tick` is high and the count is not held, `slot` rises by one at the rising edge.
- R3: When `tick` is low and there is no restart or reset, `slot` and `step_en` keep their values.
- R4: When `slot` is k, for k from 1 to 6, only `step_en` bit k-1 is high. Bit 0 is battery test, bit 1 memory test, bit 2 disk start, bit 3 display power, bit 4 boot-block read and bit 5 CPU start.
- R5: When `slot` is 0 or 7, no `step_en` bit is high.
- R6: `step_en` is registered and changes on the same edge as `slot`, so it always matches the current `slot`.
- R7: With `repeat_mode` low, once `step_en` bit 5 is high, `tick` has no effect. `slot` stays 6 until a restart or reset.
- R8: With `repeat_mode` high, the count goes 6, 7, 0, 1 and so on under ticks, and the sequence repeats.
- R9: `restart` high at an edge sets `slot` to 0 after that edge, even if `tick` is high. Counting resumes from 0 on later ticks.
- R10: At most one `step_en` bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Advance qualifier for the counter |
| restart | input | 1 | Clears the count to 0 so the sequence can run again |
| repeat_mode | input | 1 | 1 bypasses the halt feedback so the counter wraps |
| step_en | output | 6 | One-hot step enables, active high |
| slot | output | 3 | Current counter value |

## Verification
The hardest situations to reach are the final step in hold mode with ticks still arriving, and the 7-to-0 wrap, which can only happen when feedback is off. The stimulus first runs a full sequence into the hold and keeps ticking there. It then restarts with `tick` high in the same cycle, changes the tick pattern, and switches to repeat mode to cross the wrap. A restart and a reset in the middle of a sequence check the clearing paths at arbitrary counts.

// File: rtl/seq_pkg.sv
package seq_pkg;
  parameter int unsigned SEQ_CNT_W  = 3;
  parameter int unsigned SEQ_FIRST  = 1;
  parameter int unsigned SEQ_NSTEPS = 6;
endpackage

// File: rtl/seq_counter.sv
module seq_counter #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_d
);
  always_comb begin
    if (rst || clr)  cnt_d = '0;
    else if (adv)    cnt_d = cnt_q + W'(1);
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk) cnt_q <= cnt_d;

  // R9
  clear_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));

  // R2
  advance_by_one_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && adv) |=> (cnt_q == $past(cnt_q) + W'(1)));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !adv) |=> $stable(cnt_q));
endmodule

// File: rtl/seq_decoder.sv
module seq_decoder #(
  parameter int unsigned W     = 3,
  parameter int unsigned FIRST = 1,
  parameter int unsigned NUM   = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   sel,
  output logic [NUM-1:0] step_q
);
  logic [NUM-1:0] pick;

  for (genvar j = 0; j < NUM; j++) begin : g_line
    assign pick[j] = (sel == W'(FIRST + j));
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= '0;
    else     step_q <= pick;
  end

  // R10
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(step_q));
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import seq_pkg::*;
#(
  parameter int unsigned CNT_W  = SEQ_CNT_W,
  parameter int unsigned FIRST  = SEQ_FIRST,
  parameter int unsigned NSTEPS = SEQ_NSTEPS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              restart,
  input  logic              repeat_mode,
  output logic [NSTEPS-1:0] step_en,
  output logic [CNT_W-1:0]  slot
);
  localparam int unsigned LAST_IDX  = NSTEPS - 1;
  localparam int unsigned LAST_SLOT = FIRST + NSTEPS - 1;

  logic             adv;
  logic [CNT_W-1:0] cnt_next;

  // feedback: final step enable blocks further advance unless looping
  assign adv = tick & (repeat_mode | ~step_en[LAST_IDX]);

  seq_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (restart),
    .adv   (adv),
    .cnt_q (slot),
    .cnt_d (cnt_next)
  );

  // decoding the next count keeps the step register aligned with slot
  seq_decoder #(.W(CNT_W), .FIRST(FIRST), .NUM(NSTEPS)) u_dec (
    .clk    (clk),
    .rst    (rst),
    .sel    (cnt_next),
    .step_q (step_en)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (slot == '0 && step_en == '0));

  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!restart && !repeat_mode && step_en[LAST_IDX]) |=>
      (step_en[LAST_IDX] && $stable(slot)));

  // R4
  final_map_chk: assert property (@(posedge clk) disable iff (rst)
    (slot == CNT_W'(LAST_SLOT)) |-> step_en[LAST_IDX]);

  // R5
  spare_low_chk: assert property (@(posedge clk) disable iff (rst)
    (slot < CNT_W'(FIRST)) |-> (step_en == '0));
endmodule

// File: tb/sim_pwr_seq_top.sv
`timescale 1ns/1ps
module sim_pwr_seq_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1, tick = 1'b0, restart = 1'b0, repeat_mode = 1'b0;
  logic [5:0] step_en;
  logic [2:0] slot;
  int         n_run = 0, n_fail = 0;
  int         m_cnt = 0;

  always #2 clk = ~clk;

  pwr_seq_top u0 (
    .clk(clk), .rst(rst), .tick(tick), .restart(restart),
    .repeat_mode(repeat_mode), .step_en(step_en), .slot(slot)
  );

  function automatic logic [5:0] exp_steps(int c);
    return (c >= 1 && c <= 6) ? 6'(1 << (c - 1)) : 6'd0;
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // drive on negedge, model next count, compare after the next posedge
  task automatic cyc(logic r, logic t, logic rs, logic rp, string tag);
    rst = r; tick = t; restart = rs; repeat_mode = rp;
    if (r || rs) m_cnt = 0;
    else if (t && (rp || m_cnt != 6)) m_cnt = (m_cnt + 1) % 8;
    @(posedge clk); @(negedge clk);
    chk({tag, " slot"}, int'(slot), m_cnt);
    chk({tag, (m_cnt == 0 || m_cnt == 7) ? " R5 idle" : " R4/R6 step"},
        int'(step_en), int'(exp_steps(m_cnt)));
    chk("R10 onehot", int'($countones(step_en) <= 1), 1);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) cyc(1'b1, 1'b1, 1'b0, 1'b0, "R1 reset");
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, "R2 advance");
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, "R7 held");
    cyc(1'b0, 1'b1, 1'b1, 1'b0, "R9 restart");
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'(i % 2), 1'b0, 1'b0, "R3 gap");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, "R9 midrestart");
    for (int i = 0; i < 12; i++) cyc(1'b0, 1'b1, 1'b0, 1'b1, "R8 wrap");
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, 1'b1, "R3 still");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, "R1 midreset");
    for (int i = 0; i < 9; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, "R7 rerun");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule